// File: doc/BRIEF.md
# Cache Flush/Invalidate Sequencer

This block carries out cache maintenance that software asks for on a small direct-mapped line store. Software writes a request word. Bit 31 asks for a flush and bit 30 asks for an invalidate. A flush visits every set in turn. For each set it reads the tag and the valid and dirty state, then reads the line data. It then sends every line that is both valid and dirty to external memory through a request/acknowledge writeback port. An invalidate drops every line at once and writes nothing back.

Each request bit clears itself when its operation ends. Three status bits record flush-done, invalidate-done and flush-failed. A 5-bit state code with fixed values shows where the sequencer is. An error-address register captures the address of any writeback that comes back with a bus error. Only writebacks can load it, and software clears it by writing zero. A fill port stands in for the normal hit/miss path, so that lines can be placed into the store.

Top module: `cmaint_seq`

## Requirements
- R1: After reset, the request word, the status word, the error address, the valid and dirty vectors and `wb_req` are all zero, and the state code is 0.
- R2: A write with `sw_sel`=0 sets the flush request (bit 31) and/or the invalidate request (bit 30) from `sw_wdata`. Each bit returns to 0 by itself in the cycle its operation completes.
- R3: A flush visits the sets in ascending index order. Each set that is valid and dirty is written back with address `{tag, index, OFF_W zero bits}` (zero-extended) and the line data, and its dirty bit is cleared. Clean or invalid sets are not written back, and valid bits are kept.
- R4: The state code reads 0 when idle, 13 while reading tag and state, 12 while reading data, 15 while evicting and 17 while invalidating. For a dirty set the sequence is 13, then 12, then 15, one cycle apart after the request is taken.
- R5: In the status word, bit 31 is flush-done, bit 30 is invalidate-done and bit 29 is flush-failed. The done bits are set when their operation completes.
- R6: An accepted request carrying the flush bit clears all three status bits at the edge where it is written. An invalidate-only request clears only bit 30.
- R7: An error response to a writeback sets flush-failed. The flush still visits the remaining sets, writes back their dirty lines and then sets flush-done.
- R8: The writeback address is loaded into the error-address register on an acknowledge with error. A `sw_sel`=1 write of zero clears that register, and a non-zero write leaves it unchanged.
- R9: An invalidate clears every valid and dirty bit in a single cycle and raises no writeback.
- R10: When both request bits are written together, the flush runs to completion first and the invalidate follows.
- R11: A request write made while an operation is in progress changes neither the request bits nor the status.
- R12: While `wb_req` is high without `wb_ack`, the request, address and data stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0: request word, 1: error-address register |
| sw_wdata | input | 32 | Software write data |
| req_word | output | 32 | Request bits (31 flush, 30 invalidate) |
| stat_word | output | 32 | Status bits (31 flush-done, 30 invalidate-done, 29 flush-failed) |
| state_code | output | 5 | Sequencer state code |
| err_addr | output | ADDR_W | Captured error address |
| fill_en | input | 1 | Install a line (taken only while idle) |
| fill_idx | input | IDX_W | Set index to install |
| fill_tag | input | TAG_W | Tag to install |
| fill_data | input | DATA_W | Line data to install |
| fill_dirty | input | 1 | Dirty flag of the installed line |
| line_valid | output | SETS | Valid bit per set |
| line_dirty | output | SETS | Dirty bit per set |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |
| wb_ack | input | 1 | Writeback accepted |
| wb_err | input | 1 | Error response with the acknowledge |

## Verification
The bench builds the block with four sets, 8-bit tags, a 2-bit offset and 32-bit data. With only four sets, a single flush reaches the first and the last set and a mix of dirty and clean sets within a few dozen cycles. The bench varies the writeback acknowledge latency so that requests arrive while an eviction is still waiting. It also forces an error on a chosen address to show that the failure is captured and that the flush continues past it.

// File: rtl/cmaint_pkg.sv
// Shared definitions for the cache maintenance sequencer.
// Assumes: state code values are visible to software and must not change.
package cmaint_pkg;
    typedef enum logic [4:0] {
        ST_IDLE  = 5'd0,
        ST_DATA  = 5'd12,
        ST_TAGRD = 5'd13,
        ST_EVICT = 5'd15,
        ST_INVAL = 5'd17
    } seq_state_e;

    localparam int REQ_FLUSH_BIT = 31;
    localparam int REQ_INVAL_BIT = 30;
    localparam int ST_FDONE_BIT  = 31;
    localparam int ST_IDONE_BIT  = 30;
    localparam int ST_FFAIL_BIT  = 29;
endpackage

// File: rtl/cmaint_lines.sv
// Direct-mapped line store held in flops: valid, dirty, tag and data per set.
// Assumes: fill and dirty-clear never target the same set in one cycle;
// an invalidate overrides every other update.
module cmaint_lines #(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              inval_all,
    output logic [SETS-1:0]   valid_vec,
    output logic [SETS-1:0]   dirty_vec
);
    logic [SETS*TAG_W-1:0]  tag_flat;
    logic [SETS*DATA_W-1:0] data_flat;

    for (genvar g = 0; g < SETS; g++) begin : g_line
        logic              v_q;
        logic              d_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] x_q;

        // Per-set storage update: invalidate, then fill, then dirty clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
                x_q <= '0;
            end else if (inval_all) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                v_q <= 1'b1;
                d_q <= fill_dirty;
                t_q <= fill_tag;
                x_q <= fill_data;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                d_q <= 1'b0;
            end
        end

        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
        assign tag_flat[g*TAG_W +: TAG_W]    = t_q;
        assign data_flat[g*DATA_W +: DATA_W] = x_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
    assign rd_tag   = tag_flat[rd_idx*TAG_W +: TAG_W];
    assign rd_data  = data_flat[rd_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/cmaint_errlat.sv
// Error address latch: loads the address of a writeback that got an error
// response; a software write of zero clears it.
// Assumes: a capture in the same cycle as a clear wins.
module cmaint_errlat #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              sw_clr,
    output logic [ADDR_W-1:0] err_addr
);
    // Capture or clear the stored address.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_addr <= '0;
        else if (cap_en) err_addr <= cap_addr;
        else if (sw_clr) err_addr <= '0;
    end
endmodule

// File: rtl/cmaint_fsm.sv
// Maintenance sequencer: owns the request and status bits and walks the sets
// for a flush, then runs an invalidate when one is pending.
// Assumes: requests are taken only while idle with no request outstanding.
module cmaint_fsm
    import cmaint_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_flush_in,
    input  logic              req_inval_in,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wb_ack,
    input  logic              wb_err,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx,
    output logic              inval_all,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              cap_en,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              req_flush_q,
    output logic              req_inval_q,
    output logic              fdone_q,
    output logic              idone_q,
    output logic              ffail_q,
    output logic              idle,
    output logic [4:0]        state_code
);
    seq_state_e        state_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  h_tag;
    logic [DATA_W-1:0] h_data;
    logic              step, last, flush_end, accept, ack_hit;

    assign idle     = (state_q == ST_IDLE) && !req_flush_q && !req_inval_q;
    assign accept   = req_wr && idle && (req_flush_in || req_inval_in);
    assign last     = (idx_q == IDX_W'(SETS - 1));
    assign ack_hit  = (state_q == ST_EVICT) && wb_ack;

    // Next-state selection; step means the current set is finished.
    always_comb begin
        st_d = state_q;
        step = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_flush_q)      st_d = ST_TAGRD;
                else if (req_inval_q) st_d = ST_INVAL;
            end
            ST_TAGRD: begin
                if (rd_valid && rd_dirty) st_d = ST_DATA;
                else                      step = 1'b1;
            end
            ST_DATA:  st_d = ST_EVICT;
            ST_EVICT: step = wb_ack;
            ST_INVAL: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (step) begin
            if (!last)            st_d = ST_TAGRD;
            else if (req_inval_q) st_d = ST_INVAL;
            else                  st_d = ST_IDLE;
        end
    end

    assign flush_end = step && last;

    // State, set index and the held tag/data of the set being flushed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            h_tag   <= '0;
            h_data  <= '0;
        end else begin
            state_q <= st_d;
            if (state_q == ST_IDLE)    idx_q  <= '0;
            else if (step && !last)    idx_q  <= idx_q + IDX_W'(1);
            if (state_q == ST_TAGRD)   h_tag  <= rd_tag;
            if (state_q == ST_DATA)    h_data <= rd_data;
        end
    end

    // Request bits and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_flush_q <= 1'b0;
            req_inval_q <= 1'b0;
            fdone_q     <= 1'b0;
            idone_q     <= 1'b0;
            ffail_q     <= 1'b0;
        end else if (accept) begin
            req_flush_q <= req_flush_in;
            req_inval_q <= req_inval_in;
            idone_q     <= 1'b0;
            if (req_flush_in) begin
                fdone_q <= 1'b0;
                ffail_q <= 1'b0;
            end
        end else begin
            if (ack_hit && wb_err) ffail_q <= 1'b1;
            if (flush_end) begin
                req_flush_q <= 1'b0;
                fdone_q     <= 1'b1;
            end
            if (state_q == ST_INVAL) begin
                req_inval_q <= 1'b0;
                idone_q     <= 1'b1;
            end
        end
    end

    assign rd_idx     = idx_q;
    assign clr_en     = ack_hit;
    assign clr_idx    = idx_q;
    assign inval_all  = (state_q == ST_INVAL);
    assign wb_req     = (state_q == ST_EVICT);
    assign wb_addr    = ADDR_W'({h_tag, idx_q, {OFF_W{1'b0}}});
    assign wb_data    = h_data;
    assign cap_en     = ack_hit && wb_err;
    assign cap_addr   = wb_addr;
    assign state_code = state_q;
endmodule

// File: rtl/cmaint_seq.sv
// Top of the cache maintenance sequencer: software access decode, line store,
// sequencer and error-address latch.
// Assumes: sw_sel=0 addresses the request word, sw_sel=1 the error address.
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_sel,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       req_word,
    output logic [31:0]       stat_word,
    output logic [4:0]        state_code,
    output logic [ADDR_W-1:0] err_addr,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty,
    output logic [SETS-1:0]   line_valid,
    output logic [SETS-1:0]   line_dirty,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ack,
    input  logic              wb_err
);
    logic              rd_valid, rd_dirty, clr_en, inval_all, cap_en, idle;
    logic [IDX_W-1:0]  rd_idx, clr_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] cap_addr;
    logic              rq_f, rq_i, fdone, idone, ffail;

    cmaint_lines #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en && idle), .fill_idx(fill_idx), .fill_tag(fill_tag),
        .fill_data(fill_data), .fill_dirty(fill_dirty),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_data(rd_data),
        .clr_en(clr_en), .clr_idx(clr_idx), .inval_all(inval_all),
        .valid_vec(line_valid), .dirty_vec(line_dirty)
    );

    cmaint_fsm #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
                 .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_wr(sw_wr && !sw_sel),
        .req_flush_in(sw_wdata[REQ_FLUSH_BIT]), .req_inval_in(sw_wdata[REQ_INVAL_BIT]),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
        .wb_ack(wb_ack), .wb_err(wb_err),
        .rd_idx(rd_idx), .clr_en(clr_en), .clr_idx(clr_idx), .inval_all(inval_all),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
        .cap_en(cap_en), .cap_addr(cap_addr),
        .req_flush_q(rq_f), .req_inval_q(rq_i),
        .fdone_q(fdone), .idone_q(idone), .ffail_q(ffail),
        .idle(idle), .state_code(state_code)
    );

    cmaint_errlat #(.ADDR_W(ADDR_W)) u_err (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_addr(cap_addr),
        .sw_clr(sw_wr && sw_sel && (sw_wdata == 32'd0)),
        .err_addr(err_addr)
    );

    // Assemble the software-visible words from the individual bits.
    always_comb begin
        req_word  = '0;
        stat_word = '0;
        req_word[REQ_FLUSH_BIT] = rq_f;
        req_word[REQ_INVAL_BIT] = rq_i;
        stat_word[ST_FDONE_BIT] = fdone;
        stat_word[ST_IDONE_BIT] = idone;
        stat_word[ST_FFAIL_BIT] = ffail;
    end
endmodule

// File: rtl/cmaint_chk.sv
// Protocol and sequencing checks for cmaint_seq, attached through bind.
// Assumes: observes only the ports of the top module.
module cmaint_chk #(
    parameter int SETS   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr,
    input logic              sw_sel,
    input logic [31:0]       req_word,
    input logic [31:0]       stat_word,
    input logic [4:0]        state_code,
    input logic [ADDR_W-1:0] err_addr,
    input logic [SETS-1:0]   line_valid,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic              wb_ack,
    input logic              wb_err
);
    // R12
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data)));

    // R4
    wb_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (state_code == 5'd15));

    // R9
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 5'd17) |=> (line_valid == '0));

    // R2
    flush_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_word[31]) |-> stat_word[31]);

    // R8
    err_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack && wb_err) |=> (err_addr == $past(wb_addr)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 5'd15 && !wb_ack && sw_wr && !sw_sel) |=> $stable(req_word));
endmodule

bind cmaint_seq cmaint_chk #(.SETS(SETS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel),
    .req_word(req_word), .stat_word(stat_word), .state_code(state_code),
    .err_addr(err_addr), .line_valid(line_valid),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_ack(wb_ack), .wb_err(wb_err)
);

// File: tb/sim_cmaint_seq.sv
`timescale 1ns/1ps
module sim_cmaint_seq;
    localparam int SETS = 4, TAG_W = 8, DATA_W = 32, ADDR_W = 32, OFF_W = 2;
    localparam int IDX_W = $clog2(SETS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_wr = 1'b0, sw_sel = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] req_word, stat_word;
    logic [4:0]  state_code;
    logic [ADDR_W-1:0] err_addr, wb_addr;
    logic fill_en = 1'b0, fill_dirty = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0, wb_data;
    logic [SETS-1:0] line_valid, line_dirty;
    logic wb_req, wb_ack = 1'b0, wb_err = 1'b0;

    int total = 0, bad = 0, mem_cnt = 0, mem_delay = 1;
    bit err_on = 1'b0, finished = 1'b0;
    logic [ADDR_W-1:0] err_match = '0;
    logic [63:0] exp_q[$];
    logic m_valid[SETS], m_dirty[SETS];
    logic [TAG_W-1:0] m_tag[SETS];
    logic [DATA_W-1:0] m_data[SETS];

    always #2.5 clk = ~clk;

    cmaint_seq #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .req_word(req_word), .stat_word(stat_word), .state_code(state_code), .err_addr(err_addr),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .fill_dirty(fill_dirty), .line_valid(line_valid), .line_dirty(line_dirty),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack), .wb_err(wb_err)
    );

    function automatic logic [ADDR_W-1:0] addr_of(input logic [TAG_W-1:0] t, input int i);
        return (ADDR_W'(t) << (IDX_W + OFF_W)) | (ADDR_W'(i) << OFF_W);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input bit sel, input logic [31:0] d);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic fill_line(input int i, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d, input bit dy);
        fill_en = 1'b1; fill_idx = IDX_W'(i); fill_tag = t; fill_data = d; fill_dirty = dy;
        @(negedge clk);
        fill_en = 1'b0;
        m_valid[i] = 1'b1; m_dirty[i] = dy; m_tag[i] = t; m_data[i] = d;
    endtask

    // Driver side of the scoreboard: expected writebacks, ascending index.
    task automatic push_flush();
        for (int i = 0; i < SETS; i++)
            if (m_valid[i] && m_dirty[i]) begin
                exp_q.push_back({32'(addr_of(m_tag[i], i)), 32'(m_data[i])});
                m_dirty[i] = 1'b0;
            end
    endtask

    task automatic model_inval();
        for (int i = 0; i < SETS; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    endtask

    task automatic wait_done();
        for (int n = 0; n < 500 && (req_word[31] || req_word[30]); n++) tick(1);
    endtask

    function automatic logic [SETS-1:0] mvec(input bit dsel);
        logic [SETS-1:0] v;
        for (int i = 0; i < SETS; i++) v[i] = dsel ? m_dirty[i] : m_valid[i];
        return v;
    endfunction

    // Memory responder and monitor: acks after mem_delay cycles, pops and compares.
    always @(negedge clk) begin
        wb_ack <= 1'b0;
        wb_err <= 1'b0;
        if (wb_req && !wb_ack) begin
            if (mem_cnt >= mem_delay) begin
                logic [63:0] got;
                got = {32'(wb_addr), 32'(wb_data)};
                wb_ack <= 1'b1;
                wb_err <= err_on && (wb_addr == err_match);
                mem_cnt = 0;
                if (exp_q.size() == 0)
                    check(1'b0, "R3 unexpected writeback", got, 64'd0);
                else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R3 writeback addr/data", got, e);
                end
            end else mem_cnt++;
        end
    end

    initial begin
        model_inval();
        for (int i = 0; i < SETS; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check(req_word == 0 && stat_word == 0, "R1 req/status", {req_word, stat_word}, 0);
        check(state_code == 0 && err_addr == 0 && !wb_req, "R1 state/err/wb", {27'd0, state_code, err_addr}, 0);
        check(line_valid == 0 && line_dirty == 0, "R1 lines", {line_valid, line_dirty}, 0);

        // R3/R4/R5: flush with a mix of dirty and clean sets
        fill_line(0, 8'h11, 32'hA0A0_0001, 1);
        fill_line(1, 8'h22, 32'hB0B0_0002, 0);
        fill_line(2, 8'h33, 32'hC0C0_0003, 1);
        fill_line(3, 8'h44, 32'hD0D0_0004, 1);
        push_flush();
        sw_write(0, 32'h8000_0000);
        check(req_word == 32'h8000_0000 && state_code == 0, "R2 request taken", {req_word, 27'd0, state_code}, 64'h8000_0000_0000_0000);
        tick(1);
        check(state_code == 13, "R4 tag read code", state_code, 13);
        tick(1);
        check(state_code == 12, "R4 data read code", state_code, 12);
        tick(1);
        check(state_code == 15, "R4 evict code", state_code, 15);
        wait_done();
        check(stat_word == 32'h8000_0000 && req_word == 0, "R5 flush done, R2 self clear", {req_word, stat_word}, 64'h8000_0000);
        check(line_dirty == 0 && line_valid == 4'hF, "R3 dirty cleared, valid kept", {line_valid, line_dirty}, 8'hF0);
        check(exp_q.size() == 0, "R3 all writebacks seen", exp_q.size(), 0);

        // R7/R8: error on set 1 writeback, flush continues to set 3
        fill_line(1, 8'h22, 32'hB0B0_0012, 1);
        fill_line(3, 8'h44, 32'hD0D0_0014, 1);
        err_on = 1'b1; err_match = addr_of(8'h22, 1); mem_delay = 2;
        push_flush();
        sw_write(0, 32'h8000_0000);
        wait_done();
        err_on = 1'b0;
        check(stat_word == 32'hA000_0000, "R7 fail and done", stat_word, 32'hA000_0000);
        check(exp_q.size() == 0 && line_dirty == 0, "R7 continued past error", {exp_q.size(), 28'd0, line_dirty}, 0);
        check(err_addr == addr_of(8'h22, 1), "R8 error address captured", err_addr, addr_of(8'h22, 1));
        sw_write(1, 32'h0000_1234);
        check(err_addr == addr_of(8'h22, 1), "R8 nonzero write ignored", err_addr, addr_of(8'h22, 1));
        sw_write(1, 32'h0);
        check(err_addr == 0, "R8 zero write clears", err_addr, 0);

        // R6: new flush request clears status; no dirty sets so no writeback
        sw_write(0, 32'h8000_0000);
        check(stat_word == 0, "R6 flush request clears status", stat_word, 0);
        wait_done();
        check(stat_word == 32'h8000_0000 && exp_q.size() == 0, "R6 clean flush done", stat_word, 32'h8000_0000);

        // R9/R6: invalidate only
        fill_line(2, 8'h55, 32'h5555_0002, 1);
        sw_write(0, 32'h4000_0000);
        check(stat_word == 32'h8000_0000, "R6 inval request keeps flush-done", stat_word, 32'h8000_0000);
        wait_done();
        model_inval();
        check(line_valid == 0 && line_dirty == 0, "R9 all lines dropped", {line_valid, line_dirty}, 0);
        check(stat_word == 32'hC000_0000 && req_word == 0, "R9 inval done", {req_word, stat_word}, 64'hC000_0000);

        // R10: both requests, flush first then invalidate
        fill_line(1, 8'h66, 32'h6666_0001, 1);
        fill_line(2, 8'h77, 32'h7777_0002, 0);
        push_flush();
        sw_write(0, 32'hC000_0000);
        check(stat_word == 0, "R10 status cleared", stat_word, 0);
        wait_done();
        model_inval();
        check(exp_q.size() == 0, "R10 flush wrote back before invalidate", exp_q.size(), 0);
        check(line_valid == 0 && stat_word == 32'hC000_0000, "R10 both done", {line_valid, stat_word}, 64'hC000_0000);

        // R11: request written mid-operation is ignored
        fill_line(0, 8'h88, 32'h8888_0000, 1);
        fill_line(3, 8'h99, 32'h9999_0003, 1);
        mem_delay = 6;
        push_flush();
        sw_write(0, 32'h8000_0000);
        for (int n = 0; n < 50 && state_code != 15; n++) tick(1);
        sw_write(0, 32'h4000_0000);
        check(req_word == 32'h8000_0000, "R11 busy request ignored", req_word, 32'h8000_0000);
        wait_done();
        check(line_valid == mvec(0) && stat_word == 32'h8000_0000, "R11 no invalidate ran", {line_valid, stat_word}, {4'b1001, 32'h8000_0000});
        check(line_dirty == mvec(1) && exp_q.size() == 0, "R11 flush completed", {exp_q.size(), 28'd0, line_dirty}, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule